// File: doc/BRIEF.md
# Voltage Setpoint Command Slave

This block receives core-voltage and ramp-rate commands from a host processor over a two-wire I2C bus and holds them in one setpoint register. That register feeds a reference DAC and a ramp controller, which sit outside the block. The block runs on a fast system clock. It passes SCL and SDA through two-flop synchronizers and detects their edges. It pulls SDA low through an open-drain output to acknowledge, and to shift register contents back to the host on a read.

A select input picks where the setpoint comes from. In bus mode the outputs carry the register: a 4-bit voltage code and a 2-bit slew code. In pin mode the block ignores the bus, and the two bus lines plus two extra pins form a static 4-bit voltage code. The slew output is then fixed at the start-up rate. A write updates the register during the acknowledge clock of each data byte, so several bytes may follow one address. The register holds its contents until power-on reset.

Top module: `vcmd_i2c_slave`

## Requirements
- R1: After synchronous reset, `volt_code` is 4'b1001 and `slew_code` is 2'b01.
- R2: The slave address is 7'b0001100, sent MSB first and followed by a direction bit (0 = write, 1 = read). On a match the block pulls SDA low during the ninth clock, and it does the same after every data byte it receives on a write.
- R3: After any other address the block leaves SDA released for the rest of the transfer, including during the data bytes that follow, and the register does not change until the next START.
- R4: In a write data byte (bit 7 first), bits 3..0 become the voltage code and bits 5..4 become the slew code. Bits 7..6 are ignored.
- R5: The register takes a received byte on the SCL rising edge of that byte's acknowledge clock, without waiting for STOP. The outputs show the new value while SCL is still high in that clock.
- R6: Several data bytes may follow one address in a single write, and each of them is committed in turn.
- R7: A read returns the byte {2'b00, slew, voltage} MSB first. If the master ACKs, the block sends the byte again. If the master NACKs, the block releases SDA and waits for STOP or START.
- R8: A repeated START restarts the address phase without a STOP, so a write may be followed directly by a read.
- R9: With `pin_mode` high, `volt_code` equals {code_b3, code_b2, sda_in, scl_in}, and `slew_code` is 2'b01.
- R10: With `pin_mode` high the block never pulls SDA low. Bus traffic during that time leaves the register unchanged, which shows once `pin_mode` returns low.
- R11: SDA is pulled low only in an address-acknowledge slot, a write-acknowledge slot, or a read data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high power-on reset |
| pin_mode | input | 1 | 1 selects static pin code, 0 selects the bus register |
| scl_in | input | 1 | SCL line; voltage code bit 0 in pin mode |
| sda_in | input | 1 | SDA line as seen on the wire; voltage code bit 1 in pin mode |
| code_b2 | input | 1 | Voltage code bit 2 in pin mode |
| code_b3 | input | 1 | Voltage code bit 3 in pin mode |
| sda_pull_low | output | 1 | 1 pulls SDA low (open drain) |
| volt_code | output | 4 | Voltage code to the reference DAC |
| slew_code | output | 2 | Slew-rate code to the ramp controller |

## Verification
The assertions assume that each SCL high and low phase lasts several system clocks, so that every edge is seen once after synchronization. They also assume that SDA changes only while SCL is low, except at START and STOP, and that `pin_mode` changes only while both lines are high and the bus is idle. The stimulus holds every SCL phase for eight clocks and changes SDA in the middle of the low phase. It switches modes only with both lines parked high, after waiting out the synchronizer latency.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;

    localparam int          VOLT_W      = 4;
    localparam int          SLEW_W      = 2;
    localparam int          BYTE_W      = 8;
    localparam int          SYNC_STAGES = 2;
    localparam logic [6:0]  SLAVE_ADDR  = 7'b0001100;
    localparam logic [VOLT_W-1:0] DEF_VOLT = 4'b1001;
    localparam logic [SLEW_W-1:0] DEF_SLEW = 2'b01;
    localparam logic [SLEW_W-1:0] PIN_SLEW = 2'b01;

    typedef struct packed {
        logic [SLEW_W-1:0] slew;
        logic [VOLT_W-1:0] volt;
    } setpoint_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WRITE,
        ST_WACK,
        ST_READ,
        ST_RACK
    } bus_state_e;

    function automatic setpoint_t unpack_cmd(input logic [BYTE_W-1:0] b);
        setpoint_t s;
        s.volt = b[VOLT_W-1:0];
        s.slew = b[VOLT_W+SLEW_W-1:VOLT_W];
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_readback(input setpoint_t s);
        return {{(BYTE_W-VOLT_W-SLEW_W){1'b0}}, s.slew, s.volt};
    endfunction

endpackage

// File: rtl/vcmd_sync.sv
module vcmd_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    pipe[i] <= RST_VAL;
                else if (i == 0)
                    pipe[i] <= d;
                else
                    pipe[i] <= pipe[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/vcmd_bus_fsm.sv
module vcmd_bus_fsm
    import vcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_off,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_low,
    output logic              commit,
    output logic [BYTE_W-1:0] wr_byte
);
    localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

    logic              scl_q, sda_q;
    bus_state_e        st;
    logic [2:0]        cnt;
    logic              done;
    logic              rw_q;
    logic              ack_ok;
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    wire scl_rise = scl_s & ~scl_q;
    wire scl_fall = ~scl_s & scl_q;
    wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
    wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

    always_ff @(posedge clk) begin
        if (rst || bus_off) begin
            st      <= ST_IDLE;
            sda_low <= 1'b0;
            cnt     <= '0;
            done    <= 1'b0;
            rw_q    <= 1'b0;
            ack_ok  <= 1'b0;
            sh      <= '0;
        end else if (start_c) begin
            st      <= ST_ADDR;
            sda_low <= 1'b0;
            cnt     <= '0;
            done    <= 1'b0;
        end else if (stop_c) begin
            st      <= ST_IDLE;
            sda_low <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_ADDR, ST_WRITE: begin
                    if (scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 3'd1;
                        if (cnt == LAST_BIT) done <= 1'b1;
                    end else if (scl_fall && done) begin
                        done <= 1'b0;
                        cnt  <= '0;
                        if (st == ST_WRITE) begin
                            st      <= ST_WACK;
                            sda_low <= 1'b1;
                        end else if (sh[BYTE_W-1:1] == SLAVE_ADDR) begin
                            st      <= ST_AACK;
                            sda_low <= 1'b1;
                            rw_q    <= sh[0];
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw_q) begin
                            st      <= ST_READ;
                            sh      <= rd_byte;
                            sda_low <= ~rd_byte[BYTE_W-1];
                        end else begin
                            st      <= ST_WRITE;
                            sda_low <= 1'b0;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        st      <= ST_WRITE;
                        sda_low <= 1'b0;
                    end
                end
                ST_READ: begin
                    if (scl_fall) begin
                        if (cnt == LAST_BIT) begin
                            st      <= ST_RACK;
                            sda_low <= 1'b0;
                        end else begin
                            sh      <= {sh[BYTE_W-2:0], 1'b0};
                            sda_low <= ~sh[BYTE_W-2];
                            cnt     <= cnt + 3'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ack_ok <= ~sda_s;
                    end else if (scl_fall) begin
                        cnt <= '0;
                        if (ack_ok) begin
                            st      <= ST_READ;
                            sh      <= rd_byte;
                            sda_low <= ~rd_byte[BYTE_W-1];
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign commit  = (st == ST_WACK) && scl_rise && !bus_off;
    assign wr_byte = sh;

    AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        sda_low |-> (st == ST_AACK || st == ST_WACK || st == ST_READ)); // R11
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_low); // R3
    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_off |=> !sda_low); // R10
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == 3'd0)); // R2
endmodule

// File: rtl/vcmd_setpoint.sv
module vcmd_setpoint
    import vcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [BYTE_W-1:0] wr_byte,
    output setpoint_t         sp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sp.volt <= DEF_VOLT;
            sp.slew <= DEF_SLEW;
        end else if (commit) begin
            sp <= unpack_cmd(wr_byte);
        end
    end

    AST_POR_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sp.volt == DEF_VOLT && sp.slew == DEF_SLEW)); // R1
    AST_COMMIT_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) |-> $stable(sp)); // R5
endmodule

// File: rtl/vcmd_src_mux.sv
module vcmd_src_mux
    import vcmd_pkg::*;
(
    input  logic              pin_sel,
    input  logic [VOLT_W-1:0] pin_code,
    input  setpoint_t         sp,
    output logic [VOLT_W-1:0] volt,
    output logic [SLEW_W-1:0] slew
);
    always_comb begin
        if (pin_sel) begin
            volt = pin_code;
            slew = PIN_SLEW;
        end else begin
            volt = sp.volt;
            slew = sp.slew;
        end
    end
endmodule

// File: rtl/vcmd_i2c_slave.sv
module vcmd_i2c_slave
    import vcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_mode,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              code_b2,
    input  logic              code_b3,
    output logic              sda_pull_low,
    output logic [VOLT_W-1:0] volt_code,
    output logic [SLEW_W-1:0] slew_code
);
    localparam int NSYNC = VOLT_W + 1;

    logic [NSYNC-1:0]  raw_in, syn;
    logic              commit;
    logic [BYTE_W-1:0] wr_byte;
    setpoint_t         sp;

    assign raw_in = {pin_mode, code_b3, code_b2, sda_in, scl_in};

    vcmd_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b00011)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn)
    );

    vcmd_bus_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .bus_off (syn[4]),
        .scl_s   (syn[0]),
        .sda_s   (syn[1]),
        .rd_byte (pack_readback(sp)),
        .sda_low (sda_pull_low),
        .commit  (commit),
        .wr_byte (wr_byte)
    );

    vcmd_setpoint u_reg (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .wr_byte (wr_byte),
        .sp      (sp)
    );

    vcmd_src_mux u_mux (
        .pin_sel  (syn[4]),
        .pin_code (syn[VOLT_W-1:0]),
        .sp       (sp),
        .volt     (volt_code),
        .slew     (slew_code)
    );
endmodule

// File: tb/tb_vcmd_i2c_slave.sv
module tb_vcmd_i2c_slave;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_mode = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, b2 = 1'b0, b3 = 1'b0;
    logic sda_pull_low;
    logic [3:0] volt_code;
    logic [1:0] slew_code;
    wire  sda_line = sda_m & ~sda_pull_low;

    always #2.5 clk = ~clk;

    vcmd_i2c_slave dut (
        .clk(clk), .rst(rst), .pin_mode(pin_mode), .scl_in(scl_m), .sda_in(sda_line),
        .code_b2(b2), .code_b3(b3), .sda_pull_low(sda_pull_low),
        .volt_code(volt_code), .slew_code(slew_code));

    localparam int H = 8;
    int checks = 0, fails = 0, cyc = 0, quiet_bad = 0;
    bit cmp_on = 0, hold = 0, pin_phase = 0, done = 0;
    logic [3:0] ev = 4'b1001;
    logic [1:0] es = 2'b01;
    string cur_req = "R1";

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // reference model compared every clock
    always @(negedge clk) begin
        if (cmp_on && !hold && !pin_phase)
            chk(cur_req, "setpoint", {2'b00, slew_code, volt_code}, {2'b00, es, ev});
        if (pin_phase && sda_pull_low) quiet_bad++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic start_c();
        sda_m = 1; wt(H); scl_m = 1; wt(H); sda_m = 0; wt(H); scl_m = 0; wt(H/2);
    endtask

    task automatic stop_c();
        sda_m = 0; wt(H); scl_m = 1; wt(H); sda_m = 1; wt(H);
    endtask

    task automatic send(input logic [7:0] b, input bit upd, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H/2); scl_m = 1; wt(H); scl_m = 0; wt(H/2);
        end
        sda_m = 1; wt(H/2); scl_m = 1;
        if (!pin_phase) hold = 1;
        wt(5);
        ack = sda_line;
        if (upd) begin ev = b[3:0]; es = b[5:4]; end
        if (!pin_phase) begin
            hold = 0;
            if (upd) chk("R5", "commit before STOP", {2'b00, slew_code, volt_code}, {2'b00, es, ev});
        end
        wt(H-5); scl_m = 0; wt(H/2);
    endtask

    task automatic recv(input bit give_ack, output logic [7:0] v);
        v = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1; wt(H/2); scl_m = 1; wt(H/2); v = {v[6:0], sda_line}; wt(H/2); scl_m = 0; wt(H/2);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wt(H/2); scl_m = 1; wt(H); scl_m = 0; wt(H/2);
    endtask

    initial begin
        logic a;
        logic [7:0] v;
        wt(10); rst = 0; wt(1);
        cmp_on = 1;
        chk("R1", "reset volt/slew", {2'b00, slew_code, volt_code}, 8'h19);
        wt(4);

        // R2 / R4 write
        cur_req = "R4";
        start_c(); send(8'h18, 0, a); chk("R2", "address ack", {7'd0, a}, 8'h0);
        send(8'h23, 1, a); chk("R2", "data ack", {7'd0, a}, 8'h0);
        stop_c();
        start_c(); send(8'h18, 0, a);
        send(8'hC6, 1, a); chk("R4", "ack on byte with top bits set", {7'd0, a}, 8'h0);
        stop_c();
        chk("R4", "top bits ignored", {2'b00, slew_code, volt_code}, 8'h06);

        // R6 multi-byte
        cur_req = "R6";
        start_c(); send(8'h18, 0, a);
        send(8'h1F, 1, a);
        chk("R6", "first byte", {2'b00, slew_code, volt_code}, 8'h1F);
        send(8'h30, 1, a);
        chk("R6", "second byte", {2'b00, slew_code, volt_code}, 8'h30);
        stop_c();

        // R3 mismatch
        cur_req = "R3";
        start_c(); send(8'h1A, 0, a); chk("R3", "no ack on wrong address", {7'd0, a}, 8'h1);
        send(8'h05, 0, a); chk("R3", "no ack on data", {7'd0, a}, 8'h1);
        stop_c();
        chk("R3", "register unchanged", {2'b00, slew_code, volt_code}, 8'h30);

        // R7 read
        cur_req = "R7";
        start_c(); send(8'h19, 0, a); chk("R7", "read address ack", {7'd0, a}, 8'h0);
        recv(0, v); chk("R7", "read data", v, {2'b00, es, ev});
        stop_c();

        // R8 repeated start: write then read
        cur_req = "R8";
        start_c(); send(8'h18, 0, a); send(8'h2C, 1, a);
        start_c(); send(8'h19, 0, a); chk("R8", "ack after repeated start", {7'd0, a}, 8'h0);
        recv(1, v); chk("R8", "read after repeated start", v, 8'h2C);
        recv(0, v); chk("R7", "second read byte after ACK", v, 8'h2C);
        stop_c();

        // R9 pin mode
        hold = 1; pin_phase = 1; quiet_bad = 0;
        pin_mode = 1;
        for (int p = 0; p < 16; p += 5) begin
            scl_m = p[0]; sda_m = p[1]; b2 = p[2]; b3 = p[3]; wt(4);
            chk("R9", "pin code", {2'b00, slew_code, volt_code}, {2'b00, 2'b01, 4'(p)});
        end
        scl_m = 1; sda_m = 1; b2 = 0; b3 = 0; wt(4);

        // R10 bus traffic ignored in pin mode
        start_c(); send(8'h18, 0, a); chk("R10", "no ack in pin mode", {7'd0, a}, 8'h1);
        send(8'h07, 0, a); stop_c();
        chk("R10", "never pulled SDA low", quiet_bad[7:0], 8'h0);
        pin_mode = 0; wt(4); pin_phase = 0; hold = 0;
        cur_req = "R10";
        wt(2);
        chk("R10", "register kept", {2'b00, slew_code, volt_code}, 8'h2C);
        start_c(); send(8'h19, 0, a); recv(0, v); stop_c();
        chk("R10", "readback after pin mode", v, 8'h2C);

        wt(10);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule